// File: doc/BRIEF.md
# I2C Serial EEPROM Slave (1 KB, block-selected)

This block is a two-wire bus slave that behaves like a small serial EEPROM of 1024 bytes, divided into four blocks of 256 bytes. A master selects the device with a control byte. The top nibble of that byte must equal a fixed device code, bits 2:1 pick the block and bit 0 gives the direction. The block keeps one internal address pointer that is shared by writes and reads. It supports single-byte and page writes, reads from the current address, random reads (a dummy write followed by a repeated start) and sequential reads of any length.

Write data goes first into a 16-byte page buffer. The array is updated only after the master ends the transfer with a stop condition. A write cycle then runs for a fixed number of system clocks. During that cycle the device leaves its own control byte unacknowledged, so a master can poll the acknowledge bit to find out when the write has finished. SDA is open-drain: the block either pulls the line low or releases it. SCL is an input only.

Top module: `i2c_ee_slave`

## Requirements
- R1: Only a control byte whose bits 7:4 equal 4'b1010 is acknowledged, and bit 3 is ignored. For any other code the block leaves SDA released for the rest of the transfer, including every later acknowledge slot, until the next start or stop.
- R2: A write control byte (bit 0 = 0) loads the pointer's bits 9:8 from control bits 2:1. The next byte loads pointer bits 7:0. Both bytes and every data byte that follows are acknowledged (SDA low in the ninth clock).
- R3: Write data reaches the array only after the stop condition. The stop then starts a write cycle of WR_CYCLES system clocks, after which the written bytes read back.
- R4: While a write cycle runs, no control byte is acknowledged, whether it is a read or a write. Once the cycle ends, the control byte is acknowledged again.
- R5: During a write, each data byte advances only pointer bits 3:0, which wrap within the 16-byte page while bits 9:4 stay fixed. A byte sent beyond 16 overwrites an earlier byte of the same page.
- R6: A read control byte (bit 0 = 1) with no preceding address returns the byte at the current pointer. The pointer then advances by one for each byte sent.
- R7: A random read, made of control byte and word address, a repeated start, then a read control byte, returns the bytes starting at the address just loaded.
- R8: A sequential read advances the full 10-bit pointer. It moves from the end of one block into the next, and from address 1023 back to 0.
- R9: When the master answers a read byte with NACK, the block releases SDA and ignores further clocks until a start or stop, and the pointer does not move again.
- R10: After reset, SDA is released, the pointer is 0 and every byte reads 8'hFF.
- R11: A write transfer that carries a word address but no data byte starts no write cycle. The next control byte is acknowledged at once.
- R12: The block bits of a read control byte are ignored, and the read uses the current pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire (wired-AND) |
| sda_o | output | 1 | Data line drive: 0 pulls low, 1 releases |

## Verification
The main function is exercised with several transfer shapes:
- A single-byte write and a page write that starts near the end of a page and overruns it by two bytes. The overrun separates page wrap from linear increment, and shows that the extra bytes replace earlier entries.
- Reads from the current address, random reads, and sequential reads that cross a block boundary and the top of memory. These separate the 4-bit increment used for writes from the 10-bit increment used for reads.
- Acknowledge polling right after a stop, which separates a buffered write from an immediate one.
- An address-only write, which separates a stop that commits data from one that does not.
- Read control bytes with mismatched block bits, a foreign device code, and clocks sent after a NACK. These show which fields the block ignores, observed through what SDA carries.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } ee_state_e;

  typedef enum logic [1:0] {
    K_CTRL,
    K_ADDR,
    K_DATA
  } ee_kind_e;
endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [1:0] scl_sync_q, sda_sync_q;
  logic       scl_prev_q, sda_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= 2'b11;
      sda_sync_q <= 2'b11;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[0], scl_i};
      sda_sync_q <= {sda_sync_q[0], sda_i};
      scl_prev_q <= scl_sync_q[1];
      sda_prev_q <= sda_sync_q[1];
    end
  end

  assign sda_o      = sda_sync_q[1];
  assign scl_rise_o = scl_sync_q[1] & ~scl_prev_q;
  assign scl_fall_o = ~scl_sync_q[1] & scl_prev_q;
  // data edges while the clock stays high mark bus conditions
  assign start_o    = scl_sync_q[1] & scl_prev_q & sda_prev_q & ~sda_sync_q[1];
  assign stop_o     = scl_sync_q[1] & scl_prev_q & ~sda_prev_q & sda_sync_q[1];
endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int Depth = 1 << ADDR_W;

  logic [7:0] mem_q [Depth];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < Depth; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ee_wr_engine.sv
module ee_wr_engine #(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 2000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     buf_clr_i,
  input  logic                     buf_we_i,
  input  logic [PAGE_W-1:0]        buf_idx_i,
  input  logic [7:0]               buf_data_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_base_i,
  input  logic                     commit_i,
  output logic                     buf_any_o,
  output logic                     busy_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [7:0]               mem_data_o
);
  localparam int PageBytes = 1 << PAGE_W;
  localparam int CntW      = $clog2(WR_CYCLES + 1);

  logic [7:0]               buf_q [PageBytes];
  logic [PageBytes-1:0]     valid_q;
  logic [ADDR_W-PAGE_W-1:0] base_q;
  logic                     busy_q;
  logic [CntW-1:0]          cnt_q;
  logic [PAGE_W-1:0]        slot;

  assign slot = cnt_q[PAGE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PageBytes; i++) buf_q[i] <= 8'h00;
      valid_q <= '0;
      base_q  <= '0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (buf_clr_i) valid_q <= '0;
      if (buf_we_i) begin
        buf_q[buf_idx_i]   <= buf_data_i;
        valid_q[buf_idx_i] <= 1'b1;
        base_q             <= page_base_i;
      end
      if (busy_q) begin
        if (cnt_q == CntW'(WR_CYCLES - 1)) begin
          busy_q  <= 1'b0;
          valid_q <= '0;
        end
        cnt_q <= cnt_q + CntW'(1);
      end else if (commit_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  // buffered slots drain one per clock at the head of the cycle
  assign mem_we_o   = busy_q && (cnt_q < CntW'(PageBytes)) && valid_q[slot];
  assign mem_addr_o = {base_q, slot};
  assign mem_data_o = buf_q[slot];
  assign buf_any_o  = |valid_q;
  assign busy_o     = busy_q;

  a_r4_no_fill_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !buf_we_i);
  a_r11_commit_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(buf_any_o));
endmodule

// File: rtl/ee_proto_fsm.sv
module ee_proto_fsm
  import ee_pkg::*;
#(
  parameter int         ADDR_W   = 10,
  parameter int         PAGE_W   = 4,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_rise_i,
  input  logic                     scl_fall_i,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     sda_i,
  input  logic                     busy_i,
  input  logic                     buf_any_i,
  input  logic [7:0]               rd_data_i,
  output logic [ADDR_W-1:0]        rd_addr_o,
  output logic                     buf_clr_o,
  output logic                     buf_we_o,
  output logic [PAGE_W-1:0]        buf_idx_o,
  output logic [7:0]               buf_data_o,
  output logic [ADDR_W-PAGE_W-1:0] page_base_o,
  output logic                     commit_o,
  output logic                     sda_o
);
  localparam int BlkW = ADDR_W - 8;

  ee_state_e         state_q;
  ee_kind_e          kind_q;
  logic [7:0]        sh_q;
  logic [2:0]        cnt_q;
  logic              full_q, next_tx_q, mack_q, sda_q, ctrl_ack_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              quiet, decide, tx_load, dev_hit;

  assign quiet   = !start_i && !stop_i;
  assign decide  = quiet && (state_q == ST_RX) && full_q && scl_fall_i;
  assign tx_load = quiet && scl_fall_i &&
                   (((state_q == ST_ACK) && next_tx_q) || ((state_q == ST_RACK) && mack_q));
  assign dev_hit = (sh_q[7:4] == DEV_CODE) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      kind_q     <= K_CTRL;
      sh_q       <= '0;
      cnt_q      <= '0;
      full_q     <= 1'b0;
      next_tx_q  <= 1'b0;
      mack_q     <= 1'b0;
      sda_q      <= 1'b1;
      ctrl_ack_q <= 1'b0;
      ptr_q      <= '0;
    end else if (start_i) begin
      state_q    <= ST_RX;
      kind_q     <= K_CTRL;
      cnt_q      <= '0;
      full_q     <= 1'b0;
      sda_q      <= 1'b1;
      ctrl_ack_q <= 1'b0;
    end else if (stop_i) begin
      state_q    <= ST_IDLE;
      sda_q      <= 1'b1;
      ctrl_ack_q <= 1'b0;
    end else if (tx_load) begin
      sh_q       <= rd_data_i;
      sda_q      <= rd_data_i[7];
      ptr_q      <= ptr_q + ADDR_W'(1);
      cnt_q      <= '0;
      ctrl_ack_q <= 1'b0;
      state_q    <= ST_TX;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[6:0], sda_i};
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) full_q <= 1'b1;
          end
          if (decide) begin
            full_q <= 1'b0;
            cnt_q  <= '0;
            unique case (kind_q)
              K_CTRL: begin
                if (dev_hit) begin
                  sda_q      <= 1'b0;
                  state_q    <= ST_ACK;
                  ctrl_ack_q <= 1'b1;
                  next_tx_q  <= sh_q[0];
                  if (!sh_q[0]) begin
                    kind_q                <= K_ADDR;
                    ptr_q[ADDR_W-1:8]     <= sh_q[BlkW:1];
                  end
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              K_ADDR: begin
                sda_q      <= 1'b0;
                state_q    <= ST_ACK;
                ptr_q[7:0] <= sh_q;
                kind_q     <= K_DATA;
              end
              default: begin
                sda_q   <= 1'b0;
                state_q <= ST_ACK;
                ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + PAGE_W'(1);
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            ctrl_ack_q <= 1'b0;
            sda_q      <= 1'b1;
            state_q    <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == 3'd7) begin
              sda_q   <= 1'b1;
              state_q <= ST_RACK;
            end else begin
              sh_q  <= {sh_q[6:0], 1'b0};
              sda_q <= sh_q[6];
              cnt_q <= cnt_q + 3'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) mack_q <= !sda_i;
          if (scl_fall_i) begin
            sda_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_addr_o   = ptr_q;
  assign buf_clr_o   = decide && (kind_q == K_ADDR);
  assign buf_we_o    = decide && (kind_q == K_DATA);
  assign buf_idx_o   = ptr_q[PAGE_W-1:0];
  assign buf_data_o  = sh_q;
  assign page_base_o = ptr_q[ADDR_W-1:PAGE_W];
  assign commit_o    = stop_i && buf_any_i && !busy_i;
  assign sda_o       = sda_q;

  a_r9_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> sda_q);
  a_r4_ctrl_ack_only_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_ACK) && ctrl_ack_q) |-> !busy_i);
  a_r8_read_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));
  a_r5_page_bits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |=> (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])));
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave #(
  parameter int         MEM_BYTES  = 1024,
  parameter int         PAGE_BYTES = 16,
  parameter int         WR_CYCLES  = 2000,
  parameter logic [3:0] DEV_CODE   = 4'b1010
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o
);
  localparam int AddrW = $clog2(MEM_BYTES);
  localparam int PageW = $clog2(PAGE_BYTES);

  logic              scl_rise, scl_fall, bus_start, bus_stop, sda_s;
  logic              busy, buf_any, buf_clr, buf_we, commit, mem_we;
  logic [PageW-1:0]  buf_idx;
  logic [7:0]        buf_data, rd_data, mem_wdata;
  logic [AddrW-PageW-1:0] page_base;
  logic [AddrW-1:0]  rd_addr, mem_addr;

  ee_bus_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop),
    .sda_o      (sda_s)
  );

  ee_proto_fsm #(
    .ADDR_W   (AddrW),
    .PAGE_W   (PageW),
    .DEV_CODE (DEV_CODE)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (bus_start),
    .stop_i      (bus_stop),
    .sda_i       (sda_s),
    .busy_i      (busy),
    .buf_any_i   (buf_any),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .buf_clr_o   (buf_clr),
    .buf_we_o    (buf_we),
    .buf_idx_o   (buf_idx),
    .buf_data_o  (buf_data),
    .page_base_o (page_base),
    .commit_o    (commit),
    .sda_o       (sda_o)
  );

  ee_wr_engine #(
    .ADDR_W    (AddrW),
    .PAGE_W    (PageW),
    .WR_CYCLES (WR_CYCLES)
  ) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .buf_clr_i   (buf_clr),
    .buf_we_i    (buf_we),
    .buf_idx_i   (buf_idx),
    .buf_data_i  (buf_data),
    .page_base_i (page_base),
    .commit_i    (commit),
    .buf_any_o   (buf_any),
    .busy_o      (busy),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_data_o  (mem_wdata)
  );

  ee_mem_array #(
    .ADDR_W (AddrW)
  ) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (mem_addr),
    .wdata_i (mem_wdata),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );
endmodule

// File: tb/tb_i2c_ee_slave.sv
module tb_i2c_ee_slave;
  localparam int Q    = 10;
  localparam int WRC  = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_o;
  wire  bus_sda = m_sda & sda_o;

  always #4 clk = ~clk;

  i2c_ee_slave #(.WR_CYCLES(WRC)) dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .scl_i  (m_scl),
    .sda_i  (bus_sda),
    .sda_o  (sda_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] exp_mem [1024];
  logic [9:0] m_ptr = '0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got_val;
  event       rd_ev;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) begin
        chk(1'b0, "SCOREBOARD", got_val, 0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        chk(got_val === e, t, got_val, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic bit_cycle(input logic b, output logic s);
    m_sda = b;    tick(Q);
    m_scl = 1'b1; tick(Q);
    s = bus_sda;  tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(d[i], s);
    bit_cycle(1'b1, s);
    ack = !s;
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bit_cycle(1'b1, s);
      d = {d[6:0], s};
    end
    bit_cycle(!mack, s);
  endtask

  function automatic logic [7:0] wctrl(input logic [1:0] blk);
    return {4'b1010, 1'b0, blk, 1'b0};
  endfunction

  function automatic logic [7:0] rctrl(input logic [1:0] blk);
    return {4'b1010, 1'b0, blk, 1'b1};
  endfunction

  // driver: queue expected byte then clock it in
  task automatic rd_expect(input bit mack, input string tag);
    logic [7:0] d;
    exp_q.push_back(exp_mem[m_ptr]);
    tag_q.push_back(tag);
    m_ptr = m_ptr + 10'd1;
    rbyte(mack, d);
    got_val = d;
    ->rd_ev;
    tick(2);
  endtask

  task automatic poll_done(input logic [1:0] blk);
    bit ack;
    int polls = 0;
    ack = 1'b0;
    while (!ack && polls < 12) begin
      bstart();
      wbyte(wctrl(blk), ack);
      bstop();
      if (polls == 0) chk(!ack, "R4 busy nack", ack, 0);
      polls++;
    end
    chk(ack, "R3 write cycle ends", ack, 1);
    chk(polls >= 2, "R3 write cycle length", polls, 2);
  endtask

  task automatic write_seq(input logic [1:0] blk, input logic [7:0] word,
                           input int n, input logic [7:0] seed);
    bit ack;
    bstart();
    wbyte(wctrl(blk), ack); chk(ack, "R2 ctrl ack", ack, 1);
    wbyte(word, ack);       chk(ack, "R2 word ack", ack, 1);
    m_ptr = {blk, word};
    for (int i = 0; i < n; i++) begin
      automatic logic [7:0] d = seed + 8'(i * 7);
      wbyte(d, ack); chk(ack, "R2 data ack", ack, 1);
      exp_mem[m_ptr] = d;
      m_ptr[3:0] = m_ptr[3:0] + 4'd1;
    end
    bstop();
    if (n > 0) poll_done(blk);
  endtask

  task automatic rand_read(input logic [1:0] blk, input logic [7:0] word,
                           input logic [1:0] rblk, input int n, input string tag);
    bit ack;
    bstart();
    wbyte(wctrl(blk), ack); chk(ack, "R7 dummy ctrl ack", ack, 1);
    wbyte(word, ack);       chk(ack, "R7 dummy word ack", ack, 1);
    m_ptr = {blk, word};
    bstart();
    wbyte(rctrl(rblk), ack); chk(ack, "R7 read ctrl ack", ack, 1);
    for (int i = 0; i < n; i++) rd_expect(i < n - 1, tag);
  endtask

  task automatic cur_read(input int n, input string tag);
    bit ack;
    bstart();
    wbyte(rctrl(2'd0), ack); chk(ack, "R6 ctrl ack", ack, 1);
    for (int i = 0; i < n; i++) rd_expect(i < n - 1, tag);
    bstop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < 1024; i++) exp_mem[i] = 8'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk(sda_o === 1'b1, "R10 sda released", sda_o, 1);

    // R10: erased contents at pointer 0
    cur_read(1, "R10 erased byte");

    // R2/R3/R4 single byte, R7 read back
    write_seq(2'd1, 8'h23, 1, 8'h5A);
    rand_read(2'd1, 8'h23, 2'd1, 1, "R7 random read");
    bstop();

    // R5 page overrun, then R6 current address
    write_seq(2'd1, 8'hFC, 18, 8'h31);
    cur_read(1, "R6 current after page");
    rand_read(2'd1, 8'hF0, 2'd1, 16, "R5 page contents");
    bstop();

    // R8 block crossing and top wrap
    write_seq(2'd0, 8'hFE, 2, 8'h80);
    write_seq(2'd1, 8'h00, 2, 8'h90);
    write_seq(2'd0, 8'h00, 1, 8'hC3);
    write_seq(2'd3, 8'hFF, 1, 8'hA7);
    rand_read(2'd0, 8'hFE, 2'd0, 4, "R8 block cross");
    bstop();
    rand_read(2'd3, 8'hFF, 2'd3, 2, "R8 top wrap");
    bstop();

    // R12 read block bits ignored
    rand_read(2'd1, 8'h23, 2'd3, 1, "R12 read block ignored");
    bstop();

    // R1 foreign code and bit 3
    bstart();
    wbyte(8'hB0, ack); chk(!ack, "R1 foreign code nack", ack, 0);
    wbyte(8'h00, ack); chk(!ack, "R1 stays released", ack, 0);
    bstop();
    bstart();
    wbyte(wctrl(2'd1) | 8'h08, ack); chk(ack, "R1 bit3 ignored", ack, 1);
    wbyte(8'h40, ack); chk(ack, "R2 word ack", ack, 1);
    m_ptr = 10'h140;
    bstop();

    // R11 address-only write leaves device free
    bstart();
    wbyte(rctrl(2'd0), ack); chk(ack, "R11 no write cycle", ack, 1);
    rd_expect(1'b0, "R11 pointer from word");
    bstop();

    // R9 clocks after NACK ignored, pointer held
    rand_read(2'd1, 8'hF0, 2'd1, 1, "R9 last byte");
    rbyte(1'b0, d);
    chk(d === 8'hFF, "R9 released after nack", d, 8'hFF);
    bstop();
    cur_read(1, "R9 pointer held");

    tick(20);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule